// File: doc/BRIEF.md
# Bus Crosstalk Delay Class Monitor

This block sits beside a registered parallel bus and sees one word per clock, qualified by a valid strobe. For every wire it compares the last accepted word with the new one. Each wire that switches is a victim, and its two neighbours are aggressors. A neighbour adds a Miller weight of 0 when it moves the same way as the victim, 1 when it holds still and 2 when it moves the opposite way.

The block reports one crosstalk class per wire and the largest class on the bus. It raises a flag whenever some wire meets the worst case, which is rising against two falling neighbours or falling against two rising ones. A wire at either edge of the bus has one real neighbour. Its missing side is treated as a quiet neighbour.

Designers use the outputs to watch switching patterns on a bus, for example to count how often worst-case patterns occur or to check that a coded bus never produces them. The bus width is a parameter, with a default of 8 and a minimum of 3.

Top module: `xtalk_class_monitor`

## Requirements
- R1: While reset is low at a clock edge, all outputs become 0 after that edge and the stored previous word is cleared. The outputs are `wire_class`, `max_class` and `worst_case`.
- R2: The first valid word after reset gives class 0 on every wire, whatever its value.
- R3: A wire whose bit equals the same bit of the previous valid word gets class 0 (quiet).
- R4: A switching wire gets class 1 + wL + wR.
  - Each weight w is 0 when that neighbour switches in the same direction, 1 when the neighbour is quiet, and 2 when it switches in the opposite direction.
  - The class of wire i sits in bits [3i+2:3i] of `wire_class`, so classes run from 1 (both neighbours same) to 5 (both opposite).
- R5: Wire 0 and wire WIDTH-1 count the missing neighbour as quiet (weight 1), so an edge wire's class never exceeds 4.
- R6: `max_class` equals the largest per-wire class of the same word.
- R7: `worst_case` is 1 exactly when at least one wire has class 5.
- R8: Outputs update on the clock edge that samples `bus_valid` high, and they hold their value while `bus_valid` is low. A word presented with `bus_valid` low does not replace the stored previous word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_in | input | WIDTH | Observed bus word |
| bus_valid | input | 1 | Qualifies `bus_in` for this cycle |
| wire_class | output | 3*WIDTH | Packed per-wire class, wire i in bits [3i+2:3i] |
| worst_case | output | 1 | Some wire is in class 5 |
| max_class | output | 3 | Largest class across the bus |

## Verification
On every cycle the assertions check the following:
- a wire that did not change reads quiet;
- no class exceeds the reported maximum;
- the worst-case flag agrees with a maximum of 5;
- edge wires never reach class 5;
- outputs hold while valid is low and are all quiet after reset and on the first word.

Only the bench's scenarios can show the following:
- that each class number is correct for a given mix of same, quiet and opposite neighbours;
- that the maximum is actually reached;
- that a word presented with valid low is kept out of the history.

// File: rtl/xtalk_pkg.sv
// Package: shared types and helpers for the crosstalk class monitor.
// Assumes a class value fits in 3 bits (0 quiet, 1..5 delay classes).
package xtalk_pkg;

    localparam int CLASS_W = 3;
    localparam logic [CLASS_W-1:0] CLASS_QUIET = 3'd0;
    localparam logic [CLASS_W-1:0] CLASS_WORST = 3'd5;

    typedef logic [CLASS_W-1:0] xclass_t;

    // Transition direction of one wire between two words
    typedef enum logic [1:0] {
        DIR_QUIET = 2'd0,
        DIR_RISE  = 2'd1,
        DIR_FALL  = 2'd2
    } dir_t;

    // Decode the transition of one bit from the old to the new value
    function automatic dir_t wire_dir(input logic old_b, input logic new_b);
        if (old_b == new_b)
            return DIR_QUIET;
        else if (new_b)
            return DIR_RISE;
        else
            return DIR_FALL;
    endfunction

    // Miller weight one neighbour puts on a switching victim
    function automatic logic [1:0] nb_weight(input dir_t victim, input dir_t nb);
        if (nb == DIR_QUIET)
            return 2'd1;
        else if (nb == victim)
            return 2'd0;
        else
            return 2'd2;
    endfunction

endpackage

// File: rtl/xtalk_history.sv
// Module: xtalk_history
// Holds the last word accepted with valid high and a flag telling whether
// any word has been accepted since reset. Assumes synchronous active-low reset.
module xtalk_history #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] bus_in,
    input  logic             bus_valid,
    output logic [WIDTH-1:0] prev_word,
    output logic             primed
);

    // Capture the accepted word and mark the history as primed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_word <= '0;
            primed    <= 1'b0;
        end else if (bus_valid) begin
            prev_word <= bus_in;
            primed    <= 1'b1;
        end
    end

endmodule

// File: rtl/xtalk_wire_classifier.sv
// Module: xtalk_wire_classifier
// Combinational class of one victim wire from its own direction and the
// directions of its two neighbours. A missing neighbour must be fed as quiet.
module xtalk_wire_classifier
    import xtalk_pkg::*;
(
    input  dir_t    victim_dir,
    input  dir_t    left_dir,
    input  dir_t    right_dir,
    output xclass_t wire_cls
);

    logic [1:0]         w_left;
    logic [1:0]         w_right;
    logic [CLASS_W-1:0] w_sum;

    // Neighbour weights and their sum
    always_comb begin
        w_left  = nb_weight(victim_dir, left_dir);
        w_right = nb_weight(victim_dir, right_dir);
        w_sum   = {1'b0, w_left} + {1'b0, w_right};
    end

    // Quiet victim reports class 0, otherwise the sum plus one
    always_comb begin
        if (victim_dir == DIR_QUIET)
            wire_cls = CLASS_QUIET;
        else
            wire_cls = w_sum + 3'd1;
    end

endmodule

// File: rtl/xtalk_class_reduce.sv
// Module: xtalk_class_reduce
// Combinational bus-wide maximum class and worst-case detect over a packed
// class vector, wire i in bits [3i+2:3i].
module xtalk_class_reduce
    import xtalk_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [CLASS_W*WIDTH-1:0] cls_vec,
    output xclass_t                  cls_max,
    output logic                     any_worst
);

    logic [WIDTH-1:0] worst_bits;

    // Flag each wire that sits in the worst class
    for (genvar i = 0; i < WIDTH; i++) begin : g_worst
        assign worst_bits[i] = (cls_vec[CLASS_W*i +: CLASS_W] == CLASS_WORST);
    end

    // Linear scan for the largest class
    always_comb begin
        cls_max = CLASS_QUIET;
        for (int i = 0; i < WIDTH; i++) begin
            if (cls_vec[CLASS_W*i +: CLASS_W] > cls_max)
                cls_max = cls_vec[CLASS_W*i +: CLASS_W];
        end
    end

    assign any_worst = |worst_bits;

endmodule

// File: rtl/xtalk_class_monitor.sv
// Module: xtalk_class_monitor (top)
// Classifies every wire of a bus by the Miller coupling its neighbours put
// on it between consecutive valid words. Outputs are registered on the edge
// that samples valid high and hold otherwise. Assumes WIDTH >= 3.
module xtalk_class_monitor
    import xtalk_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WIDTH-1:0]         bus_in,
    input  logic                     bus_valid,
    output logic [CLASS_W*WIDTH-1:0] wire_class,
    output logic                     worst_case,
    output logic [CLASS_W-1:0]       max_class
);

    localparam int VEC_W = CLASS_W * WIDTH;

    if (WIDTH < 3) begin : g_width_check
        $error("xtalk_class_monitor: WIDTH must be at least 3");
    end

    logic [WIDTH-1:0] prev_word;
    logic             primed;
    dir_t             dir   [WIDTH];
    logic [VEC_W-1:0] cls_next;
    xclass_t          max_next;
    logic             worst_next;

    xtalk_history #(.WIDTH(WIDTH)) i_history (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_in    (bus_in),
        .bus_valid (bus_valid),
        .prev_word (prev_word),
        .primed    (primed)
    );

    // Per-wire direction; before the first word everything reads quiet
    for (genvar i = 0; i < WIDTH; i++) begin : g_dir
        assign dir[i] = primed ? wire_dir(prev_word[i], bus_in[i]) : DIR_QUIET;
    end

    // One classifier per wire; edge wires see a quiet phantom neighbour
    for (genvar i = 0; i < WIDTH; i++) begin : g_cls
        dir_t left_nb;
        dir_t right_nb;
        if (i == 0) begin : g_lo_edge
            assign left_nb = DIR_QUIET;
        end else begin : g_lo_inner
            assign left_nb = dir[i-1];
        end
        if (i == WIDTH - 1) begin : g_hi_edge
            assign right_nb = DIR_QUIET;
        end else begin : g_hi_inner
            assign right_nb = dir[i+1];
        end
        xtalk_wire_classifier i_wire (
            .victim_dir (dir[i]),
            .left_dir   (left_nb),
            .right_dir  (right_nb),
            .wire_cls   (cls_next[CLASS_W*i +: CLASS_W])
        );
    end

    xtalk_class_reduce #(.WIDTH(WIDTH)) i_reduce (
        .cls_vec   (cls_next),
        .cls_max   (max_next),
        .any_worst (worst_next)
    );

    // Output registers, loaded only for a valid word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wire_class <= '0;
            max_class  <= CLASS_QUIET;
            worst_case <= 1'b0;
        end else if (bus_valid) begin
            wire_class <= cls_next;
            max_class  <= max_next;
            worst_case <= worst_next;
        end
    end

endmodule

// File: rtl/xtalk_monitor_chk.sv
// Module: xtalk_monitor_chk
// Property checker for xtalk_class_monitor, attached with bind below.
// Keeps its own copy of the last valid word to judge quiet wires.
module xtalk_monitor_chk #(
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [WIDTH-1:0]   bus_in,
    input logic               bus_valid,
    input logic [3*WIDTH-1:0] wire_class,
    input logic               worst_case,
    input logic [2:0]         max_class
);

    logic             seen_q;
    logic [WIDTH-1:0] last_q;

    // Track whether a valid word was seen and what it was
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (bus_valid) begin
            seen_q <= 1'b1;
            last_q <= bus_in;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (wire_class == '0 && max_class == 3'd0 && !worst_case));

    // R2
    first_word_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !seen_q) |=> (wire_class == '0));

    // R7
    worst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        worst_case == (max_class == 3'd5));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_valid |=> ($stable(wire_class) && $stable(max_class) && $stable(worst_case)));

    // R5
    edge_wire_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wire_class[2:0] != 3'd5) && (wire_class[3*WIDTH-1 -: 3] != 3'd5));

    for (genvar i = 0; i < WIDTH; i++) begin : g_wire_chk
        // R3
        quiet_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_valid && seen_q && bus_in[i] == last_q[i]) |=> (wire_class[3*i +: 3] == 3'd0));
        // R6
        max_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
            max_class >= wire_class[3*i +: 3]);
    end

endmodule

bind xtalk_class_monitor xtalk_monitor_chk #(.WIDTH(WIDTH)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_in     (bus_in),
    .bus_valid  (bus_valid),
    .wire_class (wire_class),
    .worst_case (worst_case),
    .max_class  (max_class)
);

// File: tb/test_xtalk_class_monitor.sv
// Bench for xtalk_class_monitor at WIDTH = 8: a vector table walk followed
// by directed reset, idle-hold and worst-case tests.
module test_xtalk_class_monitor;

    localparam int W = 8;
    localparam int NVEC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  bus_in = '0;
    logic          bus_valid = 1'b0;
    logic [3*W-1:0] wire_class;
    logic          worst_case;
    logic [2:0]    max_class;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state: last accepted word and whether one exists
    logic [W-1:0] m_prev = '0;
    bit           m_seen = 1'b0;

    // Stimulus words with hand-worked maximum class and worst flag
    localparam logic [W-1:0] STIM      [NVEC] = '{8'h00, 8'h55, 8'hAA, 8'hFF, 8'h00, 8'h0F, 8'h01, 8'h02};
    localparam logic [2:0]   EXP_MAX   [NVEC] = '{3'd0, 3'd3, 3'd5, 3'd3, 3'd2, 3'd2, 3'd2, 3'd4};
    localparam logic         EXP_WORST [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};

    xtalk_class_monitor #(.WIDTH(W)) i_xtalk_class_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_in     (bus_in),
        .bus_valid  (bus_valid),
        .wire_class (wire_class),
        .worst_case (worst_case),
        .max_class  (max_class)
    );

    always #4 clk = ~clk;

    // Direction code: 0 quiet, 1 rise, 2 fall
    function automatic int tdir(input logic o, input logic n);
        if (o == n) return 0;
        return n ? 1 : 2;
    endfunction

    // Expected packed classes from the rules of R2..R5
    function automatic logic [3*W-1:0] model(input logic [W-1:0] p, input logic [W-1:0] c, input bit seen);
        logic [3*W-1:0] v = '0;
        for (int i = 0; i < W; i++) begin
            int vd = tdir(p[i], c[i]);
            int tot = 0;
            if (seen && vd != 0) begin
                for (int k = -1; k <= 1; k += 2) begin
                    int j = i + k;
                    int nd = (j < 0 || j >= W) ? 0 : tdir(p[j], c[j]);
                    tot += (nd == 0) ? 1 : ((nd == vd) ? 0 : 2);
                end
                v[3*i +: 3] = 3'(tot + 1);
            end
        end
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one valid word for one cycle and sample after the edge
    task automatic send(input logic [W-1:0] w);
        @(negedge clk);
        bus_in = w;
        bus_valid = 1'b1;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        m_seen = 1'b0;
        m_prev = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        logic [3*W-1:0] exp_v;
        logic [3*W-1:0] saved_v;
        logic [2:0]     saved_m;

        @(negedge clk);
        @(negedge clk);
        // R1: outputs cleared under reset
        check(wire_class == '0 && max_class == 0 && !worst_case, "R1", {5'd0, max_class, wire_class}, 0);
        rst_n = 1'b1;

        // Table walk: R2 on entry 0, R3/R4/R5 per wire, R6 max, R7 flag
        for (int n = 0; n < NVEC; n++) begin
            exp_v = model(m_prev, STIM[n], m_seen);
            send(STIM[n]);
            m_prev = STIM[n];
            m_seen = 1'b1;
            check(wire_class == exp_v, (n == 0) ? "R2" : "R4", 32'(wire_class), 32'(exp_v));
            check(max_class == EXP_MAX[n], "R6", 32'(max_class), 32'(EXP_MAX[n]));
            check(worst_case == EXP_WORST[n], "R7", 32'(worst_case), 32'(EXP_WORST[n]));
        end

        // R8: a word with valid low leaves outputs untouched
        saved_v = wire_class;
        saved_m = max_class;
        @(negedge clk);
        bus_in = 8'hFF;
        @(negedge clk);
        @(negedge clk);
        check(wire_class == saved_v && max_class == saved_m, "R8", 32'(wire_class), 32'(saved_v));
        // R8/R3: history still holds 0x02, so resending 0x02 is all quiet
        send(8'h02);
        check(wire_class == '0 && max_class == 0, "R8", 32'(wire_class), 0);

        // R7: single inner worst wire (02 -> 05 -> 02)
        send(8'h05);
        exp_v = model(8'h02, 8'h05, 1'b1);
        check(wire_class == exp_v && wire_class[5:3] == 3'd5, "R4", 32'(wire_class), 32'(exp_v));
        check(worst_case && max_class == 3'd5, "R7", {28'd0, worst_case, max_class}, 32'hD);
        send(8'h02);
        check(worst_case && max_class == 3'd5, "R7", {28'd0, worst_case, max_class}, 32'hD);

        // R1: reset mid-stream clears the outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(wire_class == '0 && max_class == 0 && !worst_case, "R1", 32'(wire_class), 0);
        rst_n = 1'b1;
        m_seen = 1'b0;

        // R2: first word after reset is all quiet even though it differs
        send(8'hAA);
        check(wire_class == '0 && max_class == 0, "R2", 32'(wire_class), 0);

        // R5: fully opposite swap; edge wires class 4, inner wires class 5
        send(8'h55);
        check(wire_class[2:0] == 3'd4, "R5", 32'(wire_class[2:0]), 4);
        check(wire_class[23:21] == 3'd4, "R5", 32'(wire_class[23:21]), 4);
        check(wire_class[11:9] == 3'd5, "R4", 32'(wire_class[11:9]), 5);

        // R3: mixed word, only switching bits get a class
        send(8'h57);
        exp_v = model(8'h55, 8'h57, 1'b1);
        check(wire_class == exp_v && wire_class[2:0] == 3'd0, "R3", 32'(wire_class), 32'(exp_v));

        do_reset();
        check(wire_class == '0, "R1", 32'(wire_class), 0);
        finish_run();
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule